// File: doc/BRIEF.md
# Header Parser Match-Action Stage

This block is one link in a chain that parses a frame header one 32-bit word at a time. Each stage takes the next header word along with the parse context handed on by the stage before it: a header-type code, a byte offset, a vector of property flags, a bus of 16-bit extracted fields and a running ones'-complement checksum. A small ternary rule table is searched with the type, the offset and the word. The first matching rule selects an action entry. The action rewrites the type and the offset, ORs in flags, copies either or both half-words of the word (optionally rotated) into chosen slots of the field bus, and can fold those half-words into the checksum. The updated context leaves on registered outputs one cycle later, ready for the next stage.

A full parser is built by chaining up to 32 instances, which covers a 128-byte header. Rules and actions are loaded through a simple write port, one rule per write.

Top module: `hdr_parse_stage`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and every output context register become zero.
- R2: `out_valid` equals `in_valid` one cycle later. The output context is updated only in cycles with `in_valid` high and otherwise holds its value.
- R3: The search key is `{in_type[3:0], in_ofs[7:0], in_word[31:0]}` (the word in key bits 31:0, the offset in 39:32, the type in 43:40). A rule matches when it is enabled and `((key ^ value) & care) == 0`.
- R4: When several rules match, the one with the lowest index wins.
- R5: When no rule matches, type, flags, field bus and checksum pass through unchanged and the offset advances by 4.
- R6: Action word bit 78 set means the type becomes bits 77:74; otherwise the type passes through.
- R7: Action bits 73:72 choose the offset update: 0 adds 4, 1 loads bits 71:64, 2 adds bits 71:64 (modulo 256), 3 keeps the offset.
- R8: The output flags are the input flags ORed with action bits 63:24. A flag is never cleared.
- R9: The upper half-word `in_word[31:16]` uses action bits 23 (enable), 22:17 (slot), 16:13 (left-rotate amount). The lower half-word uses bits 11, 10:5 and 4:1. An enabled half is rotated and written to slot s, which is bus bits `16*s+15 : 16*s`. When both halves target the same slot, the lower half wins. A slot number of 44 or more writes nothing.
- R10: Action bit 12 adds the unrotated upper half to the checksum, then bit 0 adds the unrotated lower half. Each addition is 16-bit ones'-complement with end-around carry.
- R11: A config write with `cfg_we` high stores the key value, the care mask, the action and the enable bit at `cfg_idx`. The new rule is used from the next cycle. A rule stored with the enable bit low never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Rule write strobe |
| cfg_idx | input | 3 | Rule index to write |
| cfg_rule_en | input | 1 | Enable bit of the written rule |
| cfg_key | input | 44 | Key value of the rule |
| cfg_care | input | 44 | Care mask (1 = compare bit) |
| cfg_act | input | 79 | Action word |
| in_valid | input | 1 | Input word and context valid |
| in_word | input | 32 | Header word for this stage |
| in_type | input | 4 | Incoming header-type code |
| in_ofs | input | 8 | Incoming byte offset |
| in_flags | input | 40 | Incoming flags |
| in_fields | input | 704 | Incoming field bus, 44 slots of 16 bits |
| in_csum | input | 16 | Incoming checksum |
| out_valid | output | 1 | Output context valid |
| out_type | output | 4 | Updated header type |
| out_ofs | output | 8 | Updated byte offset |
| out_flags | output | 40 | Updated flags |
| out_fields | output | 704 | Updated field bus |
| out_csum | output | 16 | Updated checksum |

## Verification
Two pairs of functions can act in the same cycle. The two half-word copies can target one slot, and the two checksum additions can both fire on one word. Directed rules send both halves to the same slot with different rotations; the expected slot value is the rotated lower half. Other directed rules add both halves to a checksum near 0xFFFF, so the end-around carry occurs inside the same cycle. Random rules and words then mix these cases with priority conflicts, and every result is compared against a bench model built from the requirements.

// File: rtl/hps_pkg.sv
package hps_pkg;
  parameter int HTYPE_W = 4;
  parameter int OFS_W   = 8;
  parameter int WORD_W  = 32;
  parameter int HALF_W  = 16;
  parameter int FLAG_N  = 40;
  parameter int FIELD_N = 44;
  parameter int SEL_W   = 6;
  parameter int ROT_W   = 4;

  localparam int KEY_W      = HTYPE_W + OFS_W + WORD_W;
  localparam int FBUS_W     = FIELD_N * HALF_W;
  localparam int WORD_BYTES = WORD_W / 8;

  typedef enum logic [1:0] {
    OFS_STEP = 2'd0,
    OFS_LOAD = 2'd1,
    OFS_ADD  = 2'd2,
    OFS_KEEP = 2'd3
  } ofs_op_e;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
    logic [ROT_W-1:0] rot;
    logic             sum;
  } half_act_t;

  typedef struct packed {
    logic               set_type;
    logic [HTYPE_W-1:0] new_type;
    ofs_op_e            ofs_op;
    logic [OFS_W-1:0]   ofs_val;
    logic [FLAG_N-1:0]  flag_set;
    half_act_t          hi;
    half_act_t          lo;
  } act_t;

  localparam int ACT_W = $bits(act_t);

  function automatic logic [HALF_W-1:0] rotl_half(input logic [HALF_W-1:0] x,
                                                  input logic [ROT_W-1:0] r);
    logic [2*HALF_W-1:0] t;
    t = {x, x} << r;
    return t[2*HALF_W-1:HALF_W];
  endfunction

  function automatic logic [HALF_W-1:0] oc_add(input logic [HALF_W-1:0] a,
                                               input logic [HALF_W-1:0] b);
    logic [HALF_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[HALF_W-1:0] + {{(HALF_W-1){1'b0}}, s[HALF_W]};
  endfunction
endpackage

// File: rtl/hps_rule_match.sv
module hps_rule_match
  import hps_pkg::*;
#(
  parameter int NUM_RULES = 8,
  localparam int IDX_W = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_rule_en,
  input  logic [KEY_W-1:0] cfg_key,
  input  logic [KEY_W-1:0] cfg_care,
  input  logic [KEY_W-1:0] key,
  output logic             hit,
  output logic [IDX_W-1:0] win_idx
);
  logic [KEY_W-1:0]     rule_val  [NUM_RULES];
  logic [KEY_W-1:0]     rule_care [NUM_RULES];
  logic [NUM_RULES-1:0] rule_on;
  logic [NUM_RULES-1:0] match_vec;

  // R11: enable bits reset, key storage needs no reset
  always_ff @(posedge clk) begin
    if (rst) begin
      rule_on <= '0;
    end else if (cfg_we) begin
      rule_on[cfg_idx] <= cfg_rule_en;
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      rule_val[cfg_idx]  <= cfg_key;
      rule_care[cfg_idx] <= cfg_care;
    end
  end

  // R3: ternary compare per rule
  for (genvar i = 0; i < NUM_RULES; i++) begin : g_cmp
    assign match_vec[i] = rule_on[i] && (((key ^ rule_val[i]) & rule_care[i]) == '0);
  end

  // R4: lowest index wins
  always_comb begin
    hit     = 1'b0;
    win_idx = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit     = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end

  // R4
  win_is_match_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> match_vec[win_idx]);
endmodule

// File: rtl/hps_action_ram.sv
module hps_action_ram
  import hps_pkg::*;
#(
  parameter int NUM_RULES = 8,
  localparam int IDX_W = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ACT_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output act_t             rdata
);
  logic [ACT_W-1:0] mem [NUM_RULES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = act_t'(mem[raddr]);
endmodule

// File: rtl/hps_apply.sv
module hps_apply
  import hps_pkg::*;
(
  input  logic               hit,
  input  act_t               act,
  input  logic [WORD_W-1:0]  word,
  input  logic [HTYPE_W-1:0] in_type,
  input  logic [OFS_W-1:0]   in_ofs,
  input  logic [FLAG_N-1:0]  in_flags,
  input  logic [FBUS_W-1:0]  in_fields,
  input  logic [HALF_W-1:0]  in_csum,
  output logic [HTYPE_W-1:0] nx_type,
  output logic [OFS_W-1:0]   nx_ofs,
  output logic [FLAG_N-1:0]  nx_flags,
  output logic [FBUS_W-1:0]  nx_fields,
  output logic [HALF_W-1:0]  nx_csum
);
  logic [HALF_W-1:0] hi_half, lo_half;
  assign hi_half = word[WORD_W-1:HALF_W];
  assign lo_half = word[HALF_W-1:0];

  always_comb begin
    nx_type   = in_type;
    nx_ofs    = in_ofs + OFS_W'(WORD_BYTES);
    nx_flags  = in_flags;
    nx_fields = in_fields;
    nx_csum   = in_csum;
    if (hit) begin
      // R6
      if (act.set_type) nx_type = act.new_type;
      // R7
      unique case (act.ofs_op)
        OFS_STEP: nx_ofs = in_ofs + OFS_W'(WORD_BYTES);
        OFS_LOAD: nx_ofs = act.ofs_val;
        OFS_ADD:  nx_ofs = in_ofs + act.ofs_val;
        OFS_KEEP: nx_ofs = in_ofs;
        default:  nx_ofs = in_ofs;
      endcase
      // R8
      nx_flags = in_flags | act.flag_set;
      // R9: upper first so the lower half overrides a shared slot
      if (act.hi.en && int'(act.hi.sel) < FIELD_N)
        nx_fields[int'(act.hi.sel)*HALF_W +: HALF_W] = rotl_half(hi_half, act.hi.rot);
      if (act.lo.en && int'(act.lo.sel) < FIELD_N)
        nx_fields[int'(act.lo.sel)*HALF_W +: HALF_W] = rotl_half(lo_half, act.lo.rot);
      // R10
      if (act.hi.sum) nx_csum = oc_add(nx_csum, hi_half);
      if (act.lo.sum) nx_csum = oc_add(nx_csum, lo_half);
    end
  end
endmodule

// File: rtl/hdr_parse_stage.sv
module hdr_parse_stage
  import hps_pkg::*;
#(
  parameter int NUM_RULES = 8,
  localparam int IDX_W = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_rule_en,
  input  logic [KEY_W-1:0]   cfg_key,
  input  logic [KEY_W-1:0]   cfg_care,
  input  logic [ACT_W-1:0]   cfg_act,
  input  logic               in_valid,
  input  logic [WORD_W-1:0]  in_word,
  input  logic [HTYPE_W-1:0] in_type,
  input  logic [OFS_W-1:0]   in_ofs,
  input  logic [FLAG_N-1:0]  in_flags,
  input  logic [FBUS_W-1:0]  in_fields,
  input  logic [HALF_W-1:0]  in_csum,
  output logic               out_valid,
  output logic [HTYPE_W-1:0] out_type,
  output logic [OFS_W-1:0]   out_ofs,
  output logic [FLAG_N-1:0]  out_flags,
  output logic [FBUS_W-1:0]  out_fields,
  output logic [HALF_W-1:0]  out_csum
);
  logic               hit;
  logic [IDX_W-1:0]   win_idx;
  act_t               act_rd;
  logic [HTYPE_W-1:0] nx_type;
  logic [OFS_W-1:0]   nx_ofs;
  logic [FLAG_N-1:0]  nx_flags;
  logic [FBUS_W-1:0]  nx_fields;
  logic [HALF_W-1:0]  nx_csum;

  hps_rule_match #(.NUM_RULES(NUM_RULES)) u_match (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_rule_en(cfg_rule_en),
    .cfg_key(cfg_key), .cfg_care(cfg_care),
    .key({in_type, in_ofs, in_word}),
    .hit(hit), .win_idx(win_idx)
  );

  hps_action_ram #(.NUM_RULES(NUM_RULES)) u_act (
    .clk(clk), .we(cfg_we), .waddr(cfg_idx), .wdata(cfg_act),
    .raddr(win_idx), .rdata(act_rd)
  );

  hps_apply u_apply (
    .hit(hit), .act(act_rd), .word(in_word),
    .in_type(in_type), .in_ofs(in_ofs), .in_flags(in_flags),
    .in_fields(in_fields), .in_csum(in_csum),
    .nx_type(nx_type), .nx_ofs(nx_ofs), .nx_flags(nx_flags),
    .nx_fields(nx_fields), .nx_csum(nx_csum)
  );

  // R1, R2
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_type   <= '0;
      out_ofs    <= '0;
      out_flags  <= '0;
      out_fields <= '0;
      out_csum   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_type   <= nx_type;
        out_ofs    <= nx_ofs;
        out_flags  <= nx_flags;
        out_fields <= nx_fields;
        out_csum   <= nx_csum;
      end
    end
  end

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_fields) && $stable(out_ofs)));
  // R8
  flags_keep_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((out_flags & $past(in_flags)) == $past(in_flags)));
  // R5
  miss_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !hit) |=> (out_fields == $past(in_fields) &&
                            out_csum == $past(in_csum) &&
                            out_type == $past(in_type)));
  // R10
  csum_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hit && !act_rd.hi.sum && !act_rd.lo.sum) |=> out_csum == $past(in_csum));
endmodule

// File: tb/hdr_parse_stage_tb.sv
`timescale 1ns/1ps
module hdr_parse_stage_tb;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst;
  logic cfg_we, cfg_rule_en;
  logic [2:0]   cfg_idx;
  logic [43:0]  cfg_key, cfg_care;
  logic [78:0]  cfg_act;
  logic         in_valid;
  logic [31:0]  in_word;
  logic [3:0]   in_type;
  logic [7:0]   in_ofs;
  logic [39:0]  in_flags;
  logic [703:0] in_fields;
  logic [15:0]  in_csum;
  logic         out_valid;
  logic [3:0]   out_type;
  logic [7:0]   out_ofs;
  logic [39:0]  out_flags;
  logic [703:0] out_fields;
  logic [15:0]  out_csum;

  always #5 clk = ~clk;

  hdr_parse_stage #(.NUM_RULES(NR)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_rule_en(cfg_rule_en),
    .cfg_key(cfg_key), .cfg_care(cfg_care), .cfg_act(cfg_act),
    .in_valid(in_valid), .in_word(in_word), .in_type(in_type), .in_ofs(in_ofs),
    .in_flags(in_flags), .in_fields(in_fields), .in_csum(in_csum),
    .out_valid(out_valid), .out_type(out_type), .out_ofs(out_ofs), .out_flags(out_flags),
    .out_fields(out_fields), .out_csum(out_csum)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic         b_en   [NR];
  logic [43:0]  b_val  [NR];
  logic [43:0]  b_care [NR];
  logic [78:0]  b_act  [NR];

  logic [3:0]   e_type;
  logic [7:0]   e_ofs;
  logic [39:0]  e_flags;
  logic [703:0] e_fields;
  logic [15:0]  e_csum;

  function automatic logic [15:0] m_rot(input logic [15:0] x, input logic [3:0] r);
    logic [15:0] y = x;
    for (int i = 0; i < int'(r); i++) y = {y[14:0], y[15]};
    return y;
  endfunction

  function automatic logic [15:0] m_add(input logic [15:0] a, input logic [15:0] b);
    int unsigned s = a + b;
    if (s > 32'hFFFF) s = s - 32'hFFFF;
    return s[15:0];
  endfunction

  function automatic logic [78:0] mk_act(input logic st, input logic [3:0] nt,
      input logic [1:0] op, input logic [7:0] ov, input logic [39:0] fm,
      input logic he, input logic [5:0] hs, input logic [3:0] hr, input logic hu,
      input logic le, input logic [5:0] ls, input logic [3:0] lr, input logic lu);
    return {st, nt, op, ov, fm, he, hs, hr, hu, le, ls, lr, lu};
  endfunction

  task automatic model();
    logic [43:0] k = {in_type, in_ofs, in_word};
    int win = -1;
    logic [78:0] a;
    for (int i = NR - 1; i >= 0; i--)
      if (b_en[i] && (((k ^ b_val[i]) & b_care[i]) == 44'd0)) win = i;
    e_type = in_type; e_ofs = in_ofs + 8'd4; e_flags = in_flags;
    e_fields = in_fields; e_csum = in_csum;
    if (win >= 0) begin
      a = b_act[win];
      if (a[78]) e_type = a[77:74];
      case (a[73:72])
        2'd0: e_ofs = in_ofs + 8'd4;
        2'd1: e_ofs = a[71:64];
        2'd2: e_ofs = in_ofs + a[71:64];
        default: e_ofs = in_ofs;
      endcase
      e_flags = in_flags | a[63:24];
      if (a[23] && a[22:17] < 6'd44) e_fields[int'(a[22:17])*16 +: 16] = m_rot(in_word[31:16], a[16:13]);
      if (a[11] && a[10:5] < 6'd44) e_fields[int'(a[10:5])*16 +: 16] = m_rot(in_word[15:0], a[4:1]);
      if (a[12]) e_csum = m_add(e_csum, in_word[31:16]);
      if (a[0])  e_csum = m_add(e_csum, in_word[15:0]);
    end
  endtask

  task automatic check(input string tag, input bit ok, input string what,
                       input logic [703:0] act, input logic [703:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all(input string tag);
    check(tag, out_valid === 1'b1, "valid", 704'(out_valid), 704'(1));
    check(tag, out_type === e_type, "type", 704'(out_type), 704'(e_type));
    check(tag, out_ofs === e_ofs, "ofs", 704'(out_ofs), 704'(e_ofs));
    check(tag, out_flags === e_flags, "flags", 704'(out_flags), 704'(e_flags));
    check(tag, out_fields === e_fields, "fields", out_fields, e_fields);
    check(tag, out_csum === e_csum, "csum", 704'(out_csum), 704'(e_csum));
  endtask

  task automatic wr_rule(input int idx, input logic en, input logic [43:0] v,
                         input logic [43:0] c, input logic [78:0] a);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_rule_en = en;
    cfg_key = v; cfg_care = c; cfg_act = a;
    b_en[idx] = en; b_val[idx] = v; b_care[idx] = c; b_act[idx] = a;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input string tag, input logic [31:0] w, input logic [3:0] t,
                      input logic [7:0] o, input logic [39:0] f, input logic [15:0] cs);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; in_type = t; in_ofs = o; in_flags = f; in_csum = cs;
    model();
    @(negedge clk);
    in_valid = 1'b0;
    cmp_all(tag);
  endtask

  function automatic logic [703:0] rnd_bus();
    logic [703:0] b;
    for (int i = 0; i < 22; i++) b[i*32 +: 32] = $urandom;
    return b;
  endfunction

  localparam logic [43:0] HI_CARE = {4'hF, 8'hFF, 16'hFFFF, 16'h0};

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] etys [4];
    logic [703:0] hold_f;
    logic [7:0] hold_o;
    void'($urandom(32'd2718));
    etys[0] = 16'h0800; etys[1] = 16'h86DD; etys[2] = 16'h8100; etys[3] = 16'h88CC;
    for (int i = 0; i < NR; i++) begin b_en[i] = 0; b_val[i] = 0; b_care[i] = 0; b_act[i] = 0; end
    rst = 1; cfg_we = 0; cfg_idx = 0; cfg_rule_en = 0; cfg_key = 0; cfg_care = 0; cfg_act = 0;
    in_valid = 0; in_word = 0; in_type = 0; in_ofs = 0; in_flags = 0; in_fields = 0; in_csum = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", out_valid === 0 && out_type === 0 && out_ofs === 0 && out_flags === 0 &&
          out_fields === 0 && out_csum === 0, "reset", 704'(out_valid), 704'(0));
    rst = 0;

    in_fields = rnd_bus();
    // R5: no rule enabled -> pass through, offset + 4
    send("R5", 32'h08004500, 4'd1, 8'd12, 40'h3, 16'h1234);

    // R3 R6 R7 R8 R9 R10: typed rule on type 1, offset 12, upper half 0x0800
    wr_rule(0, 1, {4'd1, 8'd12, 16'h0800, 16'h0}, HI_CARE,
            mk_act(1, 4'd2, 2'd1, 8'd2, 40'h20, 1, 6'd3, 4'd0, 1, 0, 6'd0, 4'd0, 0));
    send("R6", 32'h08004500, 4'd1, 8'd12, 40'h1, 16'h0100);
    // R3: offset differs -> miss
    send("R3", 32'h08004500, 4'd1, 8'd8, 40'h1, 16'h0100);

    // R4: rules 1 and 2 both match, rule 1 wins
    wr_rule(2, 1, {4'd3, 8'd0, 32'h0}, {4'hF, 40'h0},
            mk_act(1, 4'd9, 2'd3, 8'd0, 40'h0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr_rule(1, 1, {4'd3, 8'd0, 32'h0}, {4'hF, 40'h0},
            mk_act(1, 4'd5, 2'd2, 8'd20, 40'h80_0000_0000, 0, 0, 0, 0, 0, 0, 0, 0));
    send("R4", 32'hDEADBEEF, 4'd3, 8'd250, 40'h0, 16'h0);   // R7 add wraps

    // R9: both halves to slot 7, lower wins; rotation
    wr_rule(3, 1, {4'd4, 40'h0}, {4'hF, 40'h0},
            mk_act(0, 4'd0, 2'd3, 8'd0, 40'h0, 1, 6'd7, 4'd5, 0, 1, 6'd7, 4'd3, 0));
    send("R9", 32'h1234_8001, 4'd4, 8'd40, 40'h0, 16'h0);
    // R9: out-of-range slot writes nothing; hi goes to top slot 43
    wr_rule(3, 1, {4'd4, 40'h0}, {4'hF, 40'h0},
            mk_act(0, 4'd0, 2'd0, 8'd0, 40'h0, 1, 6'd43, 4'd1, 0, 1, 6'd50, 4'd0, 0));
    send("R9", 32'hA5A5_5A5A, 4'd4, 8'd40, 40'h0, 16'h0);

    // R10: both halves summed with end-around carry
    wr_rule(4, 1, {4'd5, 40'h0}, {4'hF, 40'h0},
            mk_act(0, 4'd0, 2'd0, 8'd0, 40'h0, 0, 0, 0, 1, 0, 0, 0, 1));
    send("R10", 32'h0001_FFFF, 4'd5, 8'd0, 40'h0, 16'hFFFF);
    send("R10", 32'h8000_8000, 4'd5, 8'd0, 40'h0, 16'h8001);

    // R11: disabled rule never matches
    wr_rule(4, 0, {4'd5, 40'h0}, {4'hF, 40'h0},
            mk_act(1, 4'd7, 2'd1, 8'd99, 40'hFF, 0, 0, 0, 1, 0, 0, 0, 1));
    send("R11", 32'h0001_FFFF, 4'd5, 8'd0, 40'h0, 16'h1111);

    // R2: idle cycle holds outputs
    hold_f = out_fields; hold_o = out_ofs;
    @(negedge clk);
    in_word = 32'hFFFF_FFFF; in_type = 4'd1; in_ofs = 8'd12; in_fields = rnd_bus();
    @(negedge clk);
    check("R2", out_valid === 0 && out_fields === hold_f && out_ofs === hold_o,
          "idle hold", 704'(out_ofs), 704'(hold_o));

    // Random rules and traffic (R3 R4 R5 R8 R9 R10 mixed)
    for (int r = 0; r < NR; r++) begin
      logic [43:0] c;
      c = {4'hF, ($urandom % 2) ? 8'hFF : 8'h00, 16'hFFFF, ($urandom % 4 == 0) ? 16'h00FF : 16'h0};
      wr_rule(r, ($urandom % 8) != 0,
              {4'($urandom % 4), 8'(($urandom % 4) * 4), etys[$urandom % 4], 16'($urandom % 4)}, c,
              {$urandom, $urandom, $urandom});
    end
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      w = {($urandom % 4 != 0) ? etys[$urandom % 4] : 16'($urandom), 16'($urandom % 8)};
      in_fields = rnd_bus();
      send("R4_rand", w, 4'($urandom % 4), 8'(($urandom % 4) * 4),
           {8'($urandom), $urandom}, 16'($urandom));
      if (n % 100 == 99)
        wr_rule(int'($urandom % NR), 1,
                {4'($urandom % 4), 8'h0, etys[$urandom % 4], 16'h0}, HI_CARE,
                {$urandom, $urandom, $urandom});
    end
    finish_run();
  end
endmodule